// File: doc/BRIEF.md
# Non-Cacheable Store Issue Controller

This block sits at the head of a store queue and hands non-cacheable stores, one at a time, to a downstream uncached-access buffer. When the head entry is marked ready and the queue is not empty, the block raises a request on a valid/ready channel. It then waits for one of two completion signals: a response in blocking mode, or an acceptance acknowledge in outstanding mode. Each store ends with exactly one advance of the read pointer and the dequeue pointer.

Outstanding mode does not go straight back to idle after the request handshake. Acceptance into the buffer can take several cycles, so the controller waits in its own acknowledge state. During that gap the head entry, which has not been retired yet, cannot be requested a second time. A pipeline flush drops a request that has not yet been accepted. A store that the buffer has already taken still runs to completion.

States: `IDLE`, `REQ` (request raised), `WAIT_RSP` (blocking, waiting for the response), `WAIT_ACK` (outstanding, waiting for the acceptance acknowledge). Transitions: IDLE→REQ on head ready with a non-empty queue and no flush. REQ→WAIT_RSP on a handshake in blocking mode. REQ→WAIT_ACK on a handshake in outstanding mode. REQ→IDLE on a flush with no handshake. WAIT_RSP→IDLE on the response. WAIT_ACK→IDLE on the acknowledge.

Top module: `nc_store_issue`

## Requirements
- R1: After reset the request valid is low, both pointers are zero (wrap flag 0, index 0), the empty flag is high and the full flag is low.
- R2: In IDLE, `head_rdy` high together with a non-empty queue and no flush raises `req_valid` in the following cycle, with `req_idx` equal to the read-pointer index. An empty queue (enqueue pointer equal to read pointer) raises no request.
- R3: While `req_valid` is high and `req_ready` is low, with no flush, `req_valid` and `req_idx` hold unchanged.
- R4: In blocking mode (`ost_mode`=0), the request handshake leads to WAIT_RSP with `req_valid` low. A `rsp_valid` pulse there advances both pointers by one and returns to IDLE.
- R5: In outstanding mode (`ost_mode`=1), the request handshake leads to WAIT_ACK with `req_valid` low until `ack_valid` arrives, however many cycles later. The acknowledge advances both pointers by one and returns to IDLE.
- R6: A completion signal that does not belong to the current wait state is ignored and moves no pointer. This covers `ack_valid` in WAIT_RSP, `rsp_valid` in WAIT_ACK, and either one in IDLE, including a duplicate acknowledge.
- R7: A flush in IDLE or in REQ without a handshake returns to IDLE and advances nothing. A flush in WAIT_RSP or WAIT_ACK is ignored, and the store still completes on its completion signal.
- R8: A flush in the same cycle as the request handshake does not cancel the store. The handshake counts as exactly one request and the store completes normally.
- R9: Each pointer is {wrap flag, index}. The index steps from DEPTH-1 to 0 and toggles the wrap flag at that step. `q_empty` is high when the enqueue pointer equals the read pointer. `q_full` is high when the indices match and the wrap flags differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ost_mode | input | 1 | 0 = blocking, 1 = outstanding |
| flush | input | 1 | Pipeline flush |
| head_rdy | input | 1 | Head entry is a non-cacheable store ready to execute |
| enq_ptr | input | IDX_W+1 | Queue enqueue pointer {wrap, index} |
| req_valid | output | 1 | Request valid to the uncached buffer |
| req_ready | input | 1 | Request accepted by the buffer |
| req_idx | output | IDX_W | Queue index of the requested store |
| rsp_valid | input | 1 | Response (blocking mode completion) |
| ack_valid | input | 1 | Acceptance acknowledge (outstanding mode completion) |
| rd_ptr | output | IDX_W+1 | Read pointer {wrap, index} |
| deq_ptr | output | IDX_W+1 | Dequeue pointer {wrap, index} |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |

## Verification
Two pairs of events can land in the same clock edge: a flush together with the request handshake, and a completion signal together with a state that should not accept it. The bench raises `flush` and `req_ready` in one cycle. It then judges the result by the fire count, which must rise by exactly one, and by the pointer, which must advance after the later response. It also pulses the completion signal of the wrong mode, and repeats acknowledges after a store has retired, checking each time that the pointers stay where they were.

// File: rtl/nc_issue_pkg.sv
package nc_issue_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REQ      = 2'd1,
        ST_WAIT_RSP = 2'd2,
        ST_WAIT_ACK = 2'd3
    } issue_st_e;
endpackage

// File: rtl/nc_ptr_step.sv
module nc_ptr_step #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W:0]   ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic             wrap_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
            idx_q  <= '0;
        end else if (step) begin
            if (idx_q == LAST) begin
                idx_q  <= '0;
                wrap_q <= ~wrap_q;
            end else begin
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    assign ptr = {wrap_q, idx_q};

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx_q) < DEPTH);
endmodule

// File: rtl/nc_issue_fsm.sv
module nc_issue_fsm
    import nc_issue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ost_mode,
    input  logic flush,
    input  logic head_go,
    input  logic req_ready,
    input  logic rsp_valid,
    input  logic ack_valid,
    output logic req_valid,
    output logic advance
);
    issue_st_e st_q, st_d;
    logic      fire;

    assign fire = req_valid && req_ready;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (head_go && !flush) st_d = ST_REQ;
            ST_REQ: begin
                if (fire)       st_d = ost_mode ? ST_WAIT_ACK : ST_WAIT_RSP;
                else if (flush) st_d = ST_IDLE;
            end
            ST_WAIT_RSP: if (rsp_valid) st_d = ST_IDLE;
            ST_WAIT_ACK: if (ack_valid) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        req_valid = 1'b0;
        advance   = 1'b0;
        unique case (st_q)
            ST_IDLE:     ;
            ST_REQ:      req_valid = 1'b1;
            ST_WAIT_RSP: advance = rsp_valid;
            ST_WAIT_ACK: advance = ack_valid;
            default:     ;
        endcase
    end

    // R2
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(head_go && !flush));
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !flush |=> req_valid);
    // R5
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !req_valid);
endmodule

// File: rtl/nc_store_issue.sv
module nc_store_issue #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ost_mode,
    input  logic             flush,
    input  logic             head_rdy,
    input  logic [IDX_W:0]   enq_ptr,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [IDX_W-1:0] req_idx,
    input  logic             rsp_valid,
    input  logic             ack_valid,
    output logic [IDX_W:0]   rd_ptr,
    output logic [IDX_W:0]   deq_ptr,
    output logic             q_empty,
    output logic             q_full
);
    localparam int N_PTR = 2;

    logic             advance;
    logic             head_go;
    logic [IDX_W:0]   ptrs [N_PTR];

    assign q_empty = (enq_ptr == rd_ptr);
    assign q_full  = (enq_ptr[IDX_W-1:0] == deq_ptr[IDX_W-1:0]) &&
                     (enq_ptr[IDX_W] != deq_ptr[IDX_W]);
    assign head_go = head_rdy && !q_empty;

    nc_issue_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ost_mode  (ost_mode),
        .flush     (flush),
        .head_go   (head_go),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .ack_valid (ack_valid),
        .req_valid (req_valid),
        .advance   (advance)
    );

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        nc_ptr_step #(.DEPTH(DEPTH)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (advance),
            .ptr   (ptrs[g])
        );
    end

    assign rd_ptr  = ptrs[0];
    assign deq_ptr = ptrs[1];
    assign req_idx = rd_ptr[IDX_W-1:0];

    // R4
    ptr_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr == deq_ptr);
    // R6
    adv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |-> $past(rsp_valid || ack_valid));
    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !flush |=> $stable(req_idx));
endmodule

// File: tb/nc_store_issue_tb.sv
module nc_store_issue_tb_top;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ost_mode = 1'b0, flush = 1'b0, head_rdy = 1'b0;
    logic [IDX_W:0] enq_ptr = '0;
    logic req_ready = 1'b0, rsp_valid = 1'b0, ack_valid = 1'b0;
    logic req_valid, q_empty, q_full;
    logic [IDX_W-1:0] req_idx;
    logic [IDX_W:0] rd_ptr, deq_ptr;

    int n_chk = 0, n_bad = 0, fires = 0;
    logic [IDX_W:0] exp_p = '0;

    always #2.5 clk = ~clk;

    nc_store_issue #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ost_mode(ost_mode), .flush(flush),
        .head_rdy(head_rdy), .enq_ptr(enq_ptr), .req_valid(req_valid),
        .req_ready(req_ready), .req_idx(req_idx), .rsp_valid(rsp_valid),
        .ack_valid(ack_valid), .rd_ptr(rd_ptr), .deq_ptr(deq_ptr),
        .q_empty(q_empty), .q_full(q_full)
    );

    always @(posedge clk) if (rst_n && req_valid && req_ready) fires <= fires + 1;

    // {mode[8], ready delay[7:5], completion delay[4:2], duplicate acks[1:0]}
    localparam logic [8:0] VEC [10] = '{
        {1'b0, 3'd0, 3'd0, 2'd0}, {1'b1, 3'd0, 3'd0, 2'd1},
        {1'b1, 3'd2, 3'd2, 2'd2}, {1'b0, 3'd3, 3'd1, 2'd1},
        {1'b1, 3'd1, 3'd5, 2'd3}, {1'b0, 3'd0, 3'd4, 2'd0},
        {1'b1, 3'd4, 3'd1, 2'd1}, {1'b0, 3'd2, 3'd2, 2'd2},
        {1'b1, 3'd0, 3'd3, 2'd1}, {1'b0, 3'd1, 3'd0, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_store(input logic md, input int rdy, input int dn, input int dup);
        int f0;
        enq_ptr = exp_p + 1'b1;
        ost_mode = md;
        head_rdy = 1'b1;
        @(negedge clk);
        head_rdy = 1'b0;
        chk(req_valid === 1'b1 && req_idx === exp_p[IDX_W-1:0], "R2", int'(req_idx), int'(exp_p[IDX_W-1:0]));
        f0 = fires;
        for (int k = 0; k < rdy; k++) begin
            @(negedge clk);
            chk(req_valid === 1'b1 && req_idx === exp_p[IDX_W-1:0], "R3", int'(req_valid), 1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(fires == f0 + 1 && req_valid === 1'b0, md ? "R5" : "R4", fires - f0, 1);
        for (int k = 0; k < dn; k++) begin
            if (k == 0) begin
                if (md) rsp_valid = 1'b1; else ack_valid = 1'b1;
            end
            @(negedge clk);
            rsp_valid = 1'b0; ack_valid = 1'b0;
            chk(req_valid === 1'b0 && rd_ptr === exp_p, "R6", int'(rd_ptr), int'(exp_p));
        end
        if (md) ack_valid = 1'b1; else rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; ack_valid = 1'b0;
        exp_p = exp_p + 1'b1;
        chk(rd_ptr === exp_p && deq_ptr === exp_p, md ? "R5" : "R4", int'(rd_ptr), int'(exp_p));
        for (int k = 0; k < dup; k++) begin
            ack_valid = 1'b1; rsp_valid = 1'b1;
            @(negedge clk);
            ack_valid = 1'b0; rsp_valid = 1'b0;
            chk(rd_ptr === exp_p && req_valid === 1'b0, "R6", int'(rd_ptr), int'(exp_p));
        end
        chk(fires == f0 + 1, "R5", fires - f0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid === 1'b0 && rd_ptr === '0 && deq_ptr === '0, "R1", int'(rd_ptr), 0);
        chk(q_empty === 1'b1 && q_full === 1'b0, "R1", int'(q_empty), 1);

        // R2: empty queue raises no request
        head_rdy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        head_rdy = 1'b0;
        chk(req_valid === 1'b0, "R2", int'(req_valid), 0);

        foreach (VEC[i]) begin
            run_store(VEC[i][8], int'(VEC[i][7:5]), int'(VEC[i][4:2]), int'(VEC[i][1:0]));
            // R9: after eight stores the index is back to 0 with the wrap flag set
            if (i == 7) chk(rd_ptr === 4'b1000, "R9", int'(rd_ptr), 8);
        end
        chk(rd_ptr === 4'b1010, "R9", int'(rd_ptr), 10);

        // R9: full / empty flags
        enq_ptr = exp_p ^ 4'b1000;
        @(negedge clk);
        chk(q_full === 1'b1 && q_empty === 1'b0, "R9", int'(q_full), 1);
        enq_ptr = exp_p;
        @(negedge clk);
        chk(q_empty === 1'b1 && q_full === 1'b0, "R9", int'(q_empty), 1);

        // R7: flush in IDLE blocks the request
        enq_ptr = exp_p + 1'b1;
        ost_mode = 1'b0;
        head_rdy = 1'b1; flush = 1'b1;
        @(negedge clk);
        head_rdy = 1'b0; flush = 1'b0;
        chk(req_valid === 1'b0, "R7", int'(req_valid), 0);

        // R7: flush in REQ without handshake drops the request
        head_rdy = 1'b1;
        @(negedge clk);
        head_rdy = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(req_valid === 1'b0 && rd_ptr === exp_p, "R7", int'(req_valid), 0);
        @(negedge clk);
        chk(req_valid === 1'b0 && rd_ptr === exp_p, "R7", int'(rd_ptr), int'(exp_p));

        // R8: flush with handshake in the same cycle keeps the store
        begin
            int f0;
            head_rdy = 1'b1;
            @(negedge clk);
            head_rdy = 1'b0;
            f0 = fires;
            flush = 1'b1; req_ready = 1'b1;
            @(negedge clk);
            flush = 1'b0; req_ready = 1'b0;
            chk(fires == f0 + 1 && req_valid === 1'b0, "R8", fires - f0, 1);
            rsp_valid = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0;
            exp_p = exp_p + 1'b1;
            chk(rd_ptr === exp_p, "R8", int'(rd_ptr), int'(exp_p));
        end

        // R7: flush in WAIT_ACK does not cancel the store
        enq_ptr = exp_p + 1'b1;
        ost_mode = 1'b1;
        head_rdy = 1'b1;
        @(negedge clk);
        head_rdy = 1'b0;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(req_valid === 1'b0 && rd_ptr === exp_p, "R7", int'(rd_ptr), int'(exp_p));
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        exp_p = exp_p + 1'b1;
        chk(rd_ptr === exp_p && deq_ptr === exp_p, "R7", int'(rd_ptr), int'(exp_p));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule